// File: doc/BRIEF.md
# Multiphase Current Unbalance Estimator

This block works out, for an N-phase buck converter, how far each phase's average current sits above or below the mean of all phases. It sees the converter only through ADC samples of the filtered, AC-coupled ripple on the input rail. A switching-period sync pulse and a finer sub-period tick set the sample instants. Sample index 0 falls at the start of phase 1's conduction. The remaining samples follow at equal steps through the period.

Each estimate starts with a pulse on the start input. The block gathers one vector of M samples. It gathers them within one switching period, or across M successive periods in undersampled mode, which takes one sample per period. A coefficient matrix is chosen from a small bank by the duty-cycle band seen when acquisition began. One time-shared multiplier applies the matrix to the vector. The common mean is then removed, each result is saturated and smoothed by a first-order low-pass, and the smoothed deviations are presented with a one-cycle valid pulse. If a sync pulse arrives outside its tolerance window, or fails to arrive, the partial vector is thrown away and acquisition waits for the next sync.

Top module: `phase_unbal_est`

## Requirements
- R1: While reset is held, and after it, `est_valid_o` and `adc_req_o` are low and every lane of `est_o` is zero.
- R2: After a start pulse, no sample is requested until a sync pulse arrives. The sync cycle itself requests sample 0.
- R3: In normal mode, sample k (k ≥ 1) is requested on the tick that brings the tick count since the last sync to k·(PER_TICKS/M_SMP). All M samples come from the same switching period.
- R4: In undersampled mode (`under_i` = 1 at the start pulse), sample k is taken in the k-th switching period after the acquisition sync, at the same tick offset k·(PER_TICKS/M_SMP).
- R5: `adc_req_o` stays high until `adc_ack_i` is seen. `adc_data_i` is captured as the sample in the cycle of the acknowledge.
- R6: The raw value for phase i is floor(Σk s_k·c(b,i,k) / 2^15). The coefficient c is (i==k) ? 16384−4096·b : 1024·(k+1)−2048+512·b·i. The band b is `band_i` sampled in the sync cycle that starts acquisition.
- R7: Deviation d_i = raw_i − floor(S·21845 / 2^16), where S is the sum of the raw values. The result is saturated to the signed EST_W range.
- R8: Each lane updates as y ← y + floor((d − y)/8), starting from 0 after reset. `est_o` holds phase i in bits [i·EST_W +: EST_W], in two's complement.
- R9: Each completed estimate gives exactly one `est_valid_o` pulse, one cycle long. `est_o` does not change in any cycle without that pulse.
- R10: During acquisition, a sync whose tick count since the previous sync lies outside [PER_TICKS−SYNC_TOL, PER_TICKS+SYNC_TOL] discards the partial vector. So does a tick count that passes PER_TICKS+SYNC_TOL. In either case the next sync restarts at sample 0.
- R11: A change of `band_i` after the acquisition sync has no effect on the estimate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | One-cycle pulse at the start of each switching period |
| tick_i | input | 1 | Sub-period tick, PER_TICKS per switching period |
| under_i | input | 1 | Undersampled mode, latched at start |
| start_i | input | 1 | Begin one estimate (taken when idle) |
| band_i | input | $clog2(N_BAND) | Duty-cycle band selecting the coefficient matrix |
| adc_req_o | output | 1 | Sample request to the ADC |
| adc_ack_i | input | 1 | ADC acknowledge, data valid |
| adc_data_i | input | SMP_W | Signed ADC sample |
| est_valid_o | output | 1 | One-cycle pulse when new estimates are present |
| est_o | output | N_PH*EST_W | Smoothed signed deviations, phase i in lane i |

## Verification
On every cycle, the assertions check these properties:
- the request handshake holds until acknowledged;
- a missing sync aborts acquisition;
- the request line never rises from idle;
- the sample index stays in range;
- the multiply-sequence done and output valid are single-cycle pulses;
- the outputs stay frozen between valid pulses.

Only the bench's scenarios can show the rest, because it depends on whole acquisitions and on arithmetic against an independent model:
- the tick offsets and period numbers at which samples are taken in each mode;
- the numeric result of the matrix product, mean removal and smoothing across successive estimates;
- the restart after an early or a missing sync;
- that a band change after the acquisition sync is ignored.

// File: rtl/pue_pkg.sv
package pue_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_ACQ, ST_CALC} pue_st_e;

  // reset-time coefficient image, Q1.15
  function automatic int coef_init(int b, int i, int k);
    return (i == k) ? (16384 - 4096 * b) : (1024 * (k + 1) - 2048 + 512 * b * i);
  endfunction
endpackage

// File: rtl/pue_timer.sv
module pue_timer #(
  parameter int PER = 12,
  parameter int TOL = 1,
  localparam int MAXC = PER + TOL + 1,
  localparam int CNW = $clog2(MAXC + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sync_i,
  input  logic           tick_i,
  output logic [CNW-1:0] pos_nxt_o,
  output logic           sync_ok_o,
  output logic           late_o
);
  logic [CNW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (sync_i) cnt_q <= '0;
    else if (tick_i && cnt_q != CNW'(MAXC)) cnt_q <= cnt_q + 1'b1;
  end

  assign pos_nxt_o = sync_i ? '0 : cnt_q + 1'b1;
  assign sync_ok_o = (cnt_q >= CNW'(PER - TOL)) && (cnt_q <= CNW'(PER + TOL));
  assign late_o    = cnt_q > CNW'(PER + TOL);

  assert_late_from_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(late_o) |-> $past(tick_i) && !$past(sync_i));
endmodule

// File: rtl/pue_mac.sv
module pue_mac import pue_pkg::*; #(
  parameter int N = 3,
  parameter int M = 3,
  parameter int SW = 12,
  parameter int CW = 16,
  parameter int NB = 4,
  localparam int BW = $clog2(NB),
  localparam int AW = SW + CW + $clog2(M) + 1,
  localparam int RW = AW - CW + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [BW-1:0]         band_i,
  input  logic [M-1:0][SW-1:0]  smp_i,
  output logic [N-1:0][RW-1:0]  raw_o,
  output logic                  done_o
);
  localparam int CLW = $clog2(M);
  localparam int RLW = $clog2(N);

  logic signed [CW-1:0] coef_q [NB][N][M];
  logic [CLW-1:0] col_q;
  logic [RLW-1:0] row_q;
  logic busy_q, done_q;
  logic signed [AW-1:0] acc_q, acc_nxt;
  logic signed [SW+CW-1:0] prod;

  // the single shared multiplier
  assign prod    = $signed(smp_i[col_q]) * coef_q[band_i][row_q][col_q];
  assign acc_nxt = acc_q + AW'(prod);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NB; b++)
        for (int i = 0; i < N; i++)
          for (int k = 0; k < M; k++)
            coef_q[b][i][k] <= CW'(coef_init(b, i, k));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; done_q <= 1'b0; acc_q <= '0;
      col_q <= '0; row_q <= '0; raw_o <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1; acc_q <= '0; col_q <= '0; row_q <= '0;
      end else if (busy_q) begin
        if (col_q == CLW'(M - 1)) begin
          raw_o[row_q] <= acc_nxt[AW-1:CW-1];
          acc_q <= '0;
          col_q <= '0;
          if (row_q == RLW'(N - 1)) begin
            busy_q <= 1'b0; done_q <= 1'b1;
          end else row_q <= row_q + 1'b1;
        end else begin
          acc_q <= acc_nxt;
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_idle_no_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_q));
endmodule

// File: rtl/pue_post.sv
module pue_post #(
  parameter int N = 3,
  parameter int RW = 16,
  parameter int OW = 16,
  parameter int SHIFT = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [N-1:0][RW-1:0] raw_i,
  output logic [N-1:0][OW-1:0] est_o,
  output logic                 valid_o
);
  localparam int RSH = 16;
  localparam int SUMW = RW + $clog2(N) + 1;
  localparam int PW = SUMW + RSH + 2;
  localparam logic signed [RSH+1:0] RECIP = (RSH+2)'((2 ** RSH + N / 2) / N);
  localparam logic signed [SUMW:0] DMAX = (SUMW+1)'(2 ** (OW - 1) - 1);
  localparam logic signed [SUMW:0] DMIN = -(SUMW+1)'(2 ** (OW - 1));

  logic signed [SUMW-1:0] sum;
  logic signed [PW-1:0]   mprod;
  logic signed [SUMW-1:0] mean;

  always_comb begin
    sum = '0;
    for (int i = 0; i < N; i++) sum = sum + SUMW'($signed(raw_i[i]));
  end
  assign mprod = PW'(sum) * PW'(RECIP);
  assign mean  = SUMW'(mprod >>> RSH);

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic signed [SUMW:0] dev;
    logic signed [OW-1:0] dsat, y_q;
    logic signed [OW:0]   diff;

    assign dev  = (SUMW+1)'($signed(raw_i[g])) - (SUMW+1)'(mean);
    assign dsat = (dev > DMAX) ? OW'(DMAX) : (dev < DMIN) ? OW'(DMIN) : OW'(dev);
    assign diff = (OW+1)'(dsat) - (OW+1)'(y_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) y_q <= '0;
      else if (load_i) y_q <= y_q + OW'(diff >>> SHIFT);
    end
    assign est_o[g] = y_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else valid_o <= load_i;
  end

  assert_valid_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_hold_between_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(est_o));
endmodule

// File: rtl/phase_unbal_est.sv
module phase_unbal_est import pue_pkg::*; #(
  parameter int N_PH = 3,
  parameter int M_SMP = 3,
  parameter int SMP_W = 12,
  parameter int COEF_W = 16,
  parameter int N_BAND = 4,
  parameter int EST_W = 16,
  parameter int PER_TICKS = 12,
  parameter int SYNC_TOL = 1,
  parameter int SMOOTH_SH = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sync_i,
  input  logic                      tick_i,
  input  logic                      under_i,
  input  logic                      start_i,
  input  logic [$clog2(N_BAND)-1:0] band_i,
  output logic                      adc_req_o,
  input  logic                      adc_ack_i,
  input  logic [SMP_W-1:0]          adc_data_i,
  output logic                      est_valid_o,
  output logic [N_PH*EST_W-1:0]     est_o
);
  localparam int BW = $clog2(N_BAND);
  localparam int SPT = PER_TICKS / M_SMP;
  localparam int IDX_W = $clog2(M_SMP);
  localparam int CNW = $clog2(PER_TICKS + SYNC_TOL + 2);
  localparam int AW = SMP_W + COEF_W + $clog2(M_SMP) + 1;
  localparam int RW = AW - COEF_W + 1;

  pue_st_e state_q;
  logic [IDX_W-1:0] idx_q;
  logic [BW-1:0] band_q;
  logic mode_q, seen_q, req_q, mac_go_q, mac_done;
  logic [M_SMP-1:0][SMP_W-1:0] smp_q;
  logic [N_PH-1:0][RW-1:0] raw;
  logic [N_PH-1:0][EST_W-1:0] est;
  logic [CNW-1:0] pos_nxt, tgt;
  logic sync_ok, late, err, hit, take;

  pue_timer #(.PER(PER_TICKS), .TOL(SYNC_TOL)) u_timer (
    .clk_i, .rst_ni, .sync_i, .tick_i,
    .pos_nxt_o(pos_nxt), .sync_ok_o(sync_ok), .late_o(late)
  );

  assign tgt  = CNW'(int'(idx_q) * SPT);
  assign err  = (sync_i && !sync_ok) || late;
  // undersampled: one sample per period, only after a fresh sync
  assign hit  = tick_i && !sync_i && !req_q && (pos_nxt == tgt) && (!mode_q || seen_q);
  assign take = adc_ack_i && req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; idx_q <= '0; band_q <= '0; mode_q <= 1'b0;
      seen_q <= 1'b0; req_q <= 1'b0; mac_go_q <= 1'b0; smp_q <= '0;
    end else begin
      mac_go_q <= 1'b0;
      if (take) req_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_ARM; mode_q <= under_i;
        end
        ST_ARM: if (sync_i) begin
          state_q <= ST_ACQ; idx_q <= '0; band_q <= band_i;
          req_q <= 1'b1; seen_q <= 1'b0;
        end
        ST_ACQ: begin
          if (err) begin
            state_q <= ST_ARM; idx_q <= '0;
          end else begin
            if (sync_i) seen_q <= 1'b1;
            if (hit) begin
              req_q <= 1'b1; seen_q <= 1'b0;
            end
            if (take) begin
              smp_q[idx_q] <= adc_data_i;
              if (idx_q == IDX_W'(M_SMP - 1)) begin
                state_q <= ST_CALC; idx_q <= '0; mac_go_q <= 1'b1;
              end else idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_CALC: if (mac_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  pue_mac #(.N(N_PH), .M(M_SMP), .SW(SMP_W), .CW(COEF_W), .NB(N_BAND)) u_mac (
    .clk_i, .rst_ni, .start_i(mac_go_q), .band_i(band_q), .smp_i(smp_q),
    .raw_o(raw), .done_o(mac_done)
  );

  pue_post #(.N(N_PH), .RW(RW), .OW(EST_W), .SHIFT(SMOOTH_SH)) u_post (
    .clk_i, .rst_ni, .load_i(mac_done), .raw_i(raw), .est_o(est), .valid_o(est_valid_o)
  );

  assign est_o     = est;
  assign adc_req_o = req_q;

  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_req_o && !adc_ack_i |=> adc_req_o);
  assert_late_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACQ) && late |=> state_q == ST_ARM);
  assert_no_req_from_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_req_o) |-> $past(state_q) != ST_IDLE);
  assert_idx_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ACQ |-> int'(idx_q) < M_SMP);
endmodule

// File: tb/phase_unbal_est_tb.sv
module phase_unbal_est_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3, M = 3, SW = 12, OW = 16, PER = 12, SPT = PER / M;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sync_i = 0, tick_i = 0, under_i = 0, start_i = 0, adc_ack_i = 0;
  logic [1:0] band_i = 0;
  logic [SW-1:0] adc_data_i = '0;
  logic adc_req_o, est_valid_o;
  logic [N*OW-1:0] est_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  phase_unbal_est u_dut (
    .clk_i(clk), .rst_ni, .sync_i, .tick_i, .under_i, .start_i, .band_i,
    .adc_req_o, .adc_ack_i, .adc_data_i, .est_valid_o, .est_o
  );

  int n_chk = 0, n_bad = 0, n_req = 0, n_valid = 0;
  int pos_b = 0, syncs_b = 0, run = 0, max_run = 0;
  int req_pos [64];
  int req_per [64];
  longint req_dat [64];
  longint y_m [N];
  logic [N*OW-1:0] last_est = '0;

  function automatic int coef(int b, int i, int k);
    return (i == k) ? (16384 - 4096 * b) : (1024 * (k + 1) - 2048 + 512 * b * i);
  endfunction

  function automatic int adc_val(int n);
    return ((n * 1237 + 211) % 4096) - 2048;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // one cycle: observe at negedge, then drive for the next edge
  task automatic cyc(bit s, bit t, bit st);
    @(negedge clk);
    if (adc_req_o) begin
      if (n_req < 64) begin
        req_pos[n_req] = pos_b; req_per[n_req] = syncs_b; req_dat[n_req] = adc_val(n_req);
      end
      adc_data_i = SW'(adc_val(n_req));
      adc_ack_i = 1'b1;
      n_req++;
    end else adc_ack_i = 1'b0;
    if (est_valid_o) begin
      n_valid++; last_est = est_o; run++;
      if (run > max_run) max_run = run;
    end else run = 0;
    sync_i = s; tick_i = t; start_i = st;
    if (s) begin pos_b = 0; syncs_b++; end
    else if (t) pos_b++;
  endtask

  task automatic ticks(int n);
    for (int j = 0; j < n; j++) begin cyc(0, 1, 0); cyc(0, 0, 0); end
  endtask

  task automatic period(int n);
    cyc(1, 0, 0);
    ticks(n);
  endtask

  task automatic model(int base, int b);
    longint raw [N];
    longint s, mean, d;
    s = 0;
    for (int i = 0; i < N; i++) begin
      longint acc = 0;
      for (int k = 0; k < M; k++) acc += req_dat[base + k] * coef(b, i, k);
      raw[i] = acc >>> 15;
      s += raw[i];
    end
    mean = (s * 21845) >>> 16;
    for (int i = 0; i < N; i++) begin
      d = raw[i] - mean;
      if (d > 32767) d = 32767;
      if (d < -32768) d = -32768;
      y_m[i] = y_m[i] + ((d - y_m[i]) >>> 3);
    end
  endtask

  task automatic check_est(string tag);
    for (int i = 0; i < N; i++) begin
      longint a = longint'($signed(last_est[i*OW +: OW]));
      chk(a == y_m[i], tag, a, y_m[i]);
    end
  endtask

  task automatic check_times(int base, bit under, string tag);
    for (int k = 0; k < M; k++) begin
      chk(req_pos[base + k] == k * SPT, tag, req_pos[base + k], k * SPT);
      chk(req_per[base + k] - req_per[base] == (under ? k : 0), tag,
          req_per[base + k] - req_per[base], under ? k : 0);
    end
  endtask

  task automatic check_hold(string tag);
    logic [N*OW-1:0] snap;
    int v0;
    snap = est_o; v0 = n_valid;
    ticks(10);
    chk(est_o == snap, tag, longint'(est_o != snap), 0);
    chk(n_valid == v0, tag, n_valid - v0, 0);
  endtask

  task automatic t_reset();
    chk(est_valid_o == 1'b0, "R1 valid", est_valid_o, 0);
    chk(adc_req_o == 1'b0, "R1 req", adc_req_o, 0);
    chk(est_o == '0, "R1 est", longint'(est_o != '0), 0);
  endtask

  task automatic t_normal(int b);
    int base, v0;
    base = n_req; v0 = n_valid;
    band_i = 2'(b); under_i = 1'b0;
    cyc(0, 0, 1);
    period(PER);
    ticks(6);
    chk(n_req - base == M, "R3 count", n_req - base, M);
    check_times(base, 0, "R3 offsets");
    chk(n_valid - v0 == 1, "R9 one pulse", n_valid - v0, 1);
    model(base, b);
    check_est("R6 R7 R8 normal");
    check_hold("R9 hold");
  endtask

  task automatic t_under(int b);
    int base, v0;
    base = n_req; v0 = n_valid;
    band_i = 2'(b); under_i = 1'b1;
    cyc(0, 0, 1);
    period(PER); period(PER); period(PER);
    ticks(6);
    chk(n_req - base == M, "R4 count", n_req - base, M);
    check_times(base, 1, "R4 offsets");
    chk(n_valid - v0 == 1, "R9 one pulse", n_valid - v0, 1);
    model(base, b);
    check_est("R4 R8 under");
  endtask

  task automatic t_band_latch();
    int base, v0;
    base = n_req; v0 = n_valid;
    band_i = 2'd1; under_i = 1'b0;
    cyc(0, 0, 1);
    ticks(3);
    chk(n_req == base, "R2 no req before sync", n_req - base, 0);
    cyc(1, 0, 0);
    ticks(2);
    band_i = 2'd3;
    ticks(PER - 2);
    ticks(6);
    chk(n_valid - v0 == 1, "R11 pulse", n_valid - v0, 1);
    model(base, 1);
    check_est("R11 band latched");
  endtask

  task automatic t_early();
    int base0, v0;
    base0 = n_req; v0 = n_valid;
    band_i = 2'd2; under_i = 1'b0;
    cyc(0, 0, 1);
    cyc(1, 0, 0);
    ticks(5);
    cyc(1, 0, 0);           // early sync
    period(PER);
    ticks(6);
    chk(n_req - base0 == 5, "R10 early requests", n_req - base0, 5);
    chk(n_valid - v0 == 1, "R10 early pulse", n_valid - v0, 1);
    check_times(n_req - M, 0, "R10 restart offsets");
    model(n_req - M, 2);
    check_est("R10 early value");
  endtask

  task automatic t_late();
    int base0, v0;
    base0 = n_req; v0 = n_valid;
    band_i = 2'd0; under_i = 1'b1;
    cyc(0, 0, 1);
    cyc(1, 0, 0);
    ticks(PER + 2);         // sync missing
    chk(n_valid == v0, "R10 no estimate on abort", n_valid - v0, 0);
    period(PER); period(PER); period(PER);
    ticks(6);
    chk(n_req - base0 == M + 1, "R10 late requests", n_req - base0, M + 1);
    chk(n_valid - v0 == 1, "R10 late pulse", n_valid - v0, 1);
    check_times(n_req - M, 1, "R10 R4 restart");
    model(n_req - M, 0);
    check_est("R10 late value");
  endtask

  initial begin
    for (int i = 0; i < N; i++) y_m[i] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    cyc(0, 0, 0);
    t_reset();
    t_normal(0);
    t_normal(2);
    t_under(1);
    t_band_latch();
    t_early();
    t_late();
    t_normal(3);
    chk(max_run == 1, "R9 pulse width", max_run, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R9 actual=timeout expected=finish");
    summary();
    $finish;
  end
endmodule